// File: doc/BRIEF.md
# Hypervisor Trap-Entry Status Recorder

This block keeps the privilege-status fields that a core with hypervisor support updates when it enters a trap handler or returns from one. It holds the current privilege level and virtualization bit. It also holds the supervisor-level trap fields (previous privilege, previous virtualization, guest previous privilege, guest-virtual-address flag) and the machine-level trap fields (previous privilege, previous virtualization, guest-virtual-address flag). The trap pipeline presents a trap with its delegation decision and a few qualifiers about the faulting access. The block commits every field change on the clock edge that accepts the trap.

The rule at the centre of the block is that the fields always record the mode that was really executing. They never record the mode that an access was borrowing. A hypervisor virtual-machine load or store issued from HS or U mode runs as though V were 1. A machine-mode access under modify-privilege runs as though it were at a lower level. Neither changes the current mode, so a trap from either records the real mode, and a plain return resumes the interrupted code. The guest-virtual-address flag reports separately whether the faulting address was a guest virtual address. For a hypervisor virtual-machine access it can therefore differ from the recorded virtualization bit.

The block also serves the return instructions. It provides the mode that each return would restore, and it applies that mode when a return is accepted.

Top module: `trap_status_recorder`

## Requirements
- R1: After reset the current mode is M (priv 3) with V=0. SPP, SPV, both GVA flags and the MPP value default to 0 (U). MPV resets to 1 and SPVP resets to 1 (both are parameter defaults).
- R2: A trap taken into HS sets SPP to 1 if the interrupted priv was S and to 0 if it was U, and sets SPV to the interrupted V. On the next cycle the current mode is S (priv 1) with V=0.
- R3: A trap into HS from V=1 loads SPVP with 1 for guest S and 0 for guest U. A trap into HS from V=0 leaves SPVP unchanged.
- R4: A memory fault caused by a hypervisor virtual-machine access taken into HS from V=0 sets SPV to 0 and the HS GVA flag to 1.
- R5: For any other memory fault taken into HS, the HS GVA flag equals the value written to SPV, which is the interrupted V.
- R6: A trap that is not a memory fault clears the GVA flag of the level it is taken into.
- R7: A trap into M sets MPP to the interrupted priv and MPV to the interrupted V, and the current mode becomes M with V=0. When the interrupted code is M running a modify-privilege access, MPP becomes 3 and MPV becomes 0.
- R8: For a memory fault taken into M, the M GVA flag is 1 if the access was a hypervisor virtual-machine access, if V was 1, or if it was a modify-privilege access while MPV was 1. Otherwise the flag is 0.
- R9: A trap raised while the current priv is M is taken into M, whatever the delegation input says.
- R10: SRET sets the current mode to priv S if SPP=1 (otherwise U), with V equal to SPV, and then clears SPP and SPV. The SRET restore outputs always show the mode an SRET would enter.
- R11: MRET sets the current priv to MPP, and sets V to MPV unless MPP is 3, in which case V is 0. It then writes MPP to 0 and MPV to 0. The MRET restore outputs always show the mode an MRET would enter.
- R12: At most one event is accepted per cycle, in the priority order trap, MRET, SRET. Access qualifiers that arrive without a trap change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_to_m | input | 1 | Delegation decision: 1 sends the trap to M, 0 to HS |
| hyp_vm_access | input | 1 | The trap comes from the explicit access of a hypervisor virtual-machine load or store |
| mem_fault | input | 1 | The trap is a memory fault |
| mprv_access | input | 1 | The faulting access was an M-mode access under modify-privilege |
| mret_req | input | 1 | MRET executes this cycle |
| sret_req | input | 1 | SRET executes this cycle |
| cur_priv | output | 2 | Current privilege (U=0, S=1, M=3) |
| cur_virt | output | 1 | Current virtualization bit |
| stat_spp | output | 1 | Supervisor previous privilege |
| stat_spv | output | 1 | Supervisor previous virtualization |
| stat_spvp | output | 1 | Guest previous privilege held by the hypervisor status |
| hs_gva | output | 1 | Guest-virtual-address flag of HS traps |
| stat_mpp | output | 2 | Machine previous privilege |
| stat_mpv | output | 1 | Machine previous virtualization |
| m_gva | output | 1 | Guest-virtual-address flag of M traps |
| sret_priv | output | 2 | Privilege an SRET would restore |
| sret_virt | output | 1 | V an SRET would restore |
| mret_priv | output | 2 | Privilege an MRET would restore |
| mret_virt | output | 1 | V an MRET would restore |

## Verification
The embedded assertions check the following on every cycle: SPVP is held across traps from V=0, the GVA flags follow the fault qualifiers, the modify-privilege trap records M, a trap from M stays in M, and each return enters the mode that was advertised one cycle earlier. Some behaviour can only be shown by the bench's event chains. One chain enters VU through MRET and then resumes it through SRET after a hypervisor-level trap. Another keeps MPV=1 so that a modify-privilege fault sets the M GVA flag. A third takes a second return after the fields were cleared and so drops into U with V=0. The bench also presents competing trap and return requests together.

// File: rtl/trec_pkg.sv
package trec_pkg;
   localparam int PRIV_W = 2;
   typedef logic [PRIV_W-1:0] priv_t;
   localparam priv_t PRIV_U = 2'd0;
   localparam priv_t PRIV_S = 2'd1;
   localparam priv_t PRIV_M = 2'd3;

   typedef struct packed {
      priv_t priv;
      logic  virt;
   } mode_t;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_TRAP_HS,
      EV_TRAP_M,
      EV_MRET,
      EV_SRET
   } ev_e;
endpackage

// File: rtl/trec_arbiter.sv
module trec_arbiter
   import trec_pkg::*;
(
   input  logic  trap_valid,
   input  logic  trap_to_m,
   input  logic  mret_req,
   input  logic  sret_req,
   input  priv_t cur_priv,
   output ev_e   ev
);
   logic force_m;

   // a trap never leaves M for a lower level
   assign force_m = (cur_priv == PRIV_M);

   always_comb begin
      ev = EV_NONE;
      if (trap_valid) begin
         ev = (trap_to_m || force_m) ? EV_TRAP_M : EV_TRAP_HS;
      end else if (mret_req) begin
         ev = EV_MRET;
      end else if (sret_req) begin
         ev = EV_SRET;
      end
   end
endmodule

// File: rtl/trec_hs_fields.sv
module trec_hs_fields
   import trec_pkg::*;
#(
   parameter bit RST_SPVP = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  take,
   input  logic  do_sret,
   input  mode_t cur,
   input  logic  hyp_vm,
   input  logic  mem_fault,
   output logic  spp,
   output logic  spv,
   output logic  spvp,
   output logic  gva,
   output mode_t ret_mode
);
   logic from_s;
   logic gva_nxt;

   assign from_s  = (cur.priv != PRIV_U);
   // guest address when the access borrowed V=1 or really ran with V=1
   assign gva_nxt = mem_fault & (hyp_vm | cur.virt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spp  <= 1'b0;
         spv  <= 1'b0;
         spvp <= RST_SPVP;
         gva  <= 1'b0;
      end else if (take) begin
         spp <= from_s;
         spv <= cur.virt;
         gva <= gva_nxt;
         if (cur.virt) begin
            spvp <= from_s;
         end
      end else if (do_sret) begin
         spp <= 1'b0;
         spv <= 1'b0;
      end
   end

   assign ret_mode.priv = spp ? PRIV_S : PRIV_U;
   assign ret_mode.virt = spv;

   // R3
   spvp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && !cur.virt |=> $stable(spvp));

   // R4
   hlv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && hyp_vm && mem_fault && !cur.virt |=> gva && !spv);

   // R5
   memf_gva_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && mem_fault && !hyp_vm |=> gva == spv);

   // R6
   hs_nomem_gva_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && !mem_fault |=> !gva);
endmodule

// File: rtl/trec_m_fields.sv
module trec_m_fields
   import trec_pkg::*;
#(
   parameter int RST_MPP  = 0,
   parameter bit RST_MPV  = 1'b1,
   parameter bit MPRV_GVA = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  take,
   input  logic  do_mret,
   input  mode_t cur,
   input  logic  hyp_vm,
   input  logic  mem_fault,
   input  logic  mprv_access,
   output priv_t mpp,
   output logic  mpv,
   output logic  gva,
   output mode_t ret_mode
);
   localparam priv_t RST_MPP_V = priv_t'(RST_MPP);

   logic mprv_term;
   logic gva_nxt;

   generate
      if (MPRV_GVA) begin : g_mprv_gva
         assign mprv_term = mprv_access & mpv;
      end else begin : g_no_mprv_gva
         assign mprv_term = 1'b0 & mprv_access;
      end
   endgenerate

   assign gva_nxt = mem_fault & (hyp_vm | cur.virt | mprv_term);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mpp <= RST_MPP_V;
         mpv <= RST_MPV;
         gva <= 1'b0;
      end else if (take) begin
         mpp <= cur.priv;
         mpv <= cur.virt;
         gva <= gva_nxt;
      end else if (do_mret) begin
         mpp <= PRIV_U;
         mpv <= 1'b0;
      end
   end

   assign ret_mode.priv = mpp;
   assign ret_mode.virt = (mpp == PRIV_M) ? 1'b0 : mpv;

   // R7
   mprv_mpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && mprv_access && cur.priv == PRIV_M |=> mpp == PRIV_M && !mpv);

   // R11
   mret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_mret |=> mpp == PRIV_U && !mpv);

   // R6
   m_nomem_gva_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && !mem_fault |=> !gva);

   // R8
   m_guest_gva_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && mem_fault && (hyp_vm || cur.virt) |=> gva);
endmodule

// File: rtl/trec_mode_seq.sv
module trec_mode_seq
   import trec_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  ev_e   ev,
   input  mode_t sret_mode,
   input  mode_t mret_mode,
   output mode_t cur
);
   mode_t nxt;

   always_comb begin
      nxt = cur;
      unique case (ev)
         EV_TRAP_HS: nxt = '{priv: PRIV_S, virt: 1'b0};
         EV_TRAP_M:  nxt = '{priv: PRIV_M, virt: 1'b0};
         EV_MRET:    nxt = mret_mode;
         EV_SRET:    nxt = sret_mode;
         default:    nxt = cur;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur <= '{priv: PRIV_M, virt: 1'b0};
      end else begin
         cur <= nxt;
      end
   end

   // R2
   hs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_TRAP_HS |=> cur.priv == PRIV_S && !cur.virt);

   // R10
   sret_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_SRET |=> cur == $past(sret_mode));

   // R11
   mret_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_MRET |=> cur == $past(mret_mode));
endmodule

// File: rtl/trap_status_recorder.sv
module trap_status_recorder
   import trec_pkg::*;
#(
   parameter int RST_MPP  = 0,
   parameter bit RST_MPV  = 1'b1,
   parameter bit RST_SPVP = 1'b1,
   parameter bit MPRV_GVA = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trap_valid,
   input  logic       trap_to_m,
   input  logic       hyp_vm_access,
   input  logic       mem_fault,
   input  logic       mprv_access,
   input  logic       mret_req,
   input  logic       sret_req,
   output logic [1:0] cur_priv,
   output logic       cur_virt,
   output logic       stat_spp,
   output logic       stat_spv,
   output logic       stat_spvp,
   output logic       hs_gva,
   output logic [1:0] stat_mpp,
   output logic       stat_mpv,
   output logic       m_gva,
   output logic [1:0] sret_priv,
   output logic       sret_virt,
   output logic [1:0] mret_priv,
   output logic       mret_virt
);
   if (PRIV_W != 2) begin : g_bad_width
      $error("privilege field must be two bits wide");
   end
   if (RST_MPP == 2 || RST_MPP < 0 || RST_MPP > 3) begin : g_bad_mpp
      $error("RST_MPP must encode U, S or M");
   end

   ev_e   ev;
   mode_t cur;
   mode_t s_ret;
   mode_t m_ret;
   priv_t mpp_q;

   trec_arbiter u_arb (
      .trap_valid (trap_valid),
      .trap_to_m  (trap_to_m),
      .mret_req   (mret_req),
      .sret_req   (sret_req),
      .cur_priv   (cur.priv),
      .ev         (ev)
   );

   trec_hs_fields #(.RST_SPVP(RST_SPVP)) u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (ev == EV_TRAP_HS),
      .do_sret   (ev == EV_SRET),
      .cur       (cur),
      .hyp_vm    (hyp_vm_access),
      .mem_fault (mem_fault),
      .spp       (stat_spp),
      .spv       (stat_spv),
      .spvp      (stat_spvp),
      .gva       (hs_gva),
      .ret_mode  (s_ret)
   );

   trec_m_fields #(.RST_MPP(RST_MPP), .RST_MPV(RST_MPV), .MPRV_GVA(MPRV_GVA)) u_m (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (ev == EV_TRAP_M),
      .do_mret     (ev == EV_MRET),
      .cur         (cur),
      .hyp_vm      (hyp_vm_access),
      .mem_fault   (mem_fault),
      .mprv_access (mprv_access),
      .mpp         (mpp_q),
      .mpv         (stat_mpv),
      .gva         (m_gva),
      .ret_mode    (m_ret)
   );

   trec_mode_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .sret_mode (s_ret),
      .mret_mode (m_ret),
      .cur       (cur)
   );

   assign cur_priv  = cur.priv;
   assign cur_virt  = cur.virt;
   assign stat_mpp  = mpp_q;
   assign sret_priv = s_ret.priv;
   assign sret_virt = s_ret.virt;
   assign mret_priv = m_ret.priv;
   assign mret_virt = m_ret.virt;

   // R9
   trap_from_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid && cur_priv == PRIV_M |=> cur_priv == PRIV_M && stat_mpp == PRIV_M);

   // R12
   trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> !cur_virt && cur_priv != PRIV_U);

   // R12
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid && !mret_req && !sret_req |=> $stable(cur_priv) && $stable(stat_spvp));
endmodule

// File: tb/trap_status_recorder_tb.sv
module trap_status_recorder_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, trap_valid, trap_to_m, hyp_vm_access, mem_fault, mprv_access, mret_req, sret_req;
   logic [1:0] cur_priv, stat_mpp, sret_priv, mret_priv;
   logic cur_virt, stat_spp, stat_spv, stat_spvp, hs_gva, stat_mpv, m_gva, sret_virt, mret_virt;

   trap_status_recorder u_dut (
      .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_to_m(trap_to_m),
      .hyp_vm_access(hyp_vm_access), .mem_fault(mem_fault), .mprv_access(mprv_access),
      .mret_req(mret_req), .sret_req(sret_req), .cur_priv(cur_priv), .cur_virt(cur_virt),
      .stat_spp(stat_spp), .stat_spv(stat_spv), .stat_spvp(stat_spvp), .hs_gva(hs_gva),
      .stat_mpp(stat_mpp), .stat_mpv(stat_mpv), .m_gva(m_gva), .sret_priv(sret_priv),
      .sret_virt(sret_virt), .mret_priv(mret_priv), .mret_virt(mret_virt)
   );

   typedef struct {
      string       tag;
      logic [16:0] exp;
   } item_t;

   item_t sbq[$];
   item_t it;
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state, built from the requirements
   logic [1:0] e_priv, e_mpp;
   logic e_virt, e_spp, e_spv, e_spvp, e_hgva, e_mpv, e_mgva;

   wire [16:0] got = {cur_priv, cur_virt, stat_spp, stat_spv, stat_spvp, hs_gva,
                      stat_mpp, stat_mpv, m_gva, sret_priv, sret_virt, mret_priv, mret_virt};

   function automatic logic [16:0] expect_vec();
      logic [1:0] sp;
      logic mv;
      sp = e_spp ? 2'd1 : 2'd0;
      mv = (e_mpp == 2'd3) ? 1'b0 : e_mpv;
      return {e_priv, e_virt, e_spp, e_spv, e_spvp, e_hgva,
              e_mpp, e_mpv, e_mgva, sp, e_spv, e_mpp, mv};
   endfunction

   task automatic compare(input string tag, input logic [16:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %05h expected %05h", tag, got, exp);
      end
   endtask

   task automatic step(input bit tv, input bit tm, input bit hv, input bit mf,
                       input bit mp, input bit mr, input bit sr, input string tag);
      item_t ni;
      @(negedge clk);
      trap_valid = tv; trap_to_m = tm; hyp_vm_access = hv;
      mem_fault = mf; mprv_access = mp; mret_req = mr; sret_req = sr;
      if (tv) begin
         if (tm || e_priv == 2'd3) begin
            e_mgva = mf & (hv | e_virt | (mp & e_mpv));
            e_mpp  = e_priv;
            e_mpv  = e_virt;
            e_priv = 2'd3;
            e_virt = 1'b0;
         end else begin
            e_hgva = mf & (hv | e_virt);
            e_spp  = (e_priv == 2'd1);
            e_spv  = e_virt;
            if (e_virt) e_spvp = (e_priv == 2'd1);
            e_priv = 2'd1;
            e_virt = 1'b0;
         end
      end else if (mr) begin
         e_priv = e_mpp;
         e_virt = (e_mpp == 2'd3) ? 1'b0 : e_mpv;
         e_mpp  = 2'd0;
         e_mpv  = 1'b0;
      end else if (sr) begin
         e_priv = e_spp ? 2'd1 : 2'd0;
         e_virt = e_spv;
         e_spp  = 1'b0;
         e_spv  = 1'b0;
      end
      ni.tag = tag;
      ni.exp = expect_vec();
      sbq.push_back(ni);
   endtask

   // monitor: one result per clock, sampled mid-cycle after the edge
   always @(posedge clk) begin
      #5;
      if (sbq.size() > 0) begin
         it = sbq.pop_front();
         compare(it.tag, it.exp);
      end
   end

   initial begin
      rst_n = 1'b0;
      trap_valid = 0; trap_to_m = 0; hyp_vm_access = 0; mem_fault = 0;
      mprv_access = 0; mret_req = 0; sret_req = 0;
      e_priv = 2'd3; e_virt = 0; e_spp = 0; e_spv = 0; e_spvp = 1; e_hgva = 0;
      e_mpp = 2'd0; e_mpv = 1; e_mgva = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1 reset state", expect_vec());

      step(0,0,1,1,1,0,0, "R12 qualifiers without trap");
      step(0,0,0,0,0,1,0, "R11 mret into VU");
      step(1,0,0,0,0,0,0, "R3 trap HS from VU loads SPVP");
      step(0,0,0,0,0,0,1, "R10 sret resumes VU");
      step(1,0,0,1,0,0,0, "R5 mem fault from VU, GVA=SPV");
      step(0,0,0,0,0,0,1, "R10 sret back to VU");
      step(1,1,0,1,0,0,0, "R8 M fault from VU sets GVA");
      step(1,0,1,1,1,0,0, "R7 mprv trap records M");
      step(0,0,0,0,0,1,0, "R11 mret with MPP=M keeps V=0");
      step(0,0,0,0,0,1,1, "R12 mret beats sret");
      step(1,1,0,0,0,0,0, "R7 trap M from U");
      step(0,0,0,0,0,1,0, "R11 mret to U");
      step(1,0,1,1,0,1,1, "R4 hlv fault from U, trap wins R12");
      step(1,0,1,1,0,0,0, "R4 hlv fault from HS, SPVP kept R3");
      step(0,0,0,0,0,0,1, "R10 sret resumes HS");
      step(1,0,0,1,0,0,0, "R5 mem fault from HS, GVA=0");
      step(1,1,0,0,0,0,0, "R6 non-mem trap to M");
      step(1,0,0,0,0,0,0, "R9 trap in M ignores delegation");
      step(0,0,0,0,0,1,0, "R11 mret with MPP=M");
      step(1,1,1,1,0,0,0, "R8 hlv fault to M sets GVA");
      step(0,0,0,0,0,1,0, "R11 mret to M");
      step(0,0,0,0,0,1,0, "R11 mret to U after clear");
      step(1,0,0,0,0,0,0, "R2 non-mem trap HS from U, R6");
      step(0,0,0,0,0,0,0, "R12 idle");
      @(negedge clk);
      trap_valid = 0; mret_req = 0; sret_req = 0; mem_fault = 0;
      hyp_vm_access = 0; mprv_access = 0;
      wait (sbq.size() == 0);
      @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R12: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule